// File: doc/BRIEF.md
# Hysteretic Supply Window Monitor

This block decides whether a digitized supply reading sits inside a programmable voltage window. The reading is an unsigned 12-bit code at 1 mV per LSB. It feeds two hysteretic limit detectors, one for the lower limit and one for the upper limit. Each detector has its own threshold and its own hysteresis. The two detector states are brought out as raw under-voltage and over-voltage flags.

The window result is "in window": neither flag is set. This result passes through a settle filter before it reaches the supply-good output. The filter runs on a timebase tick. Supply-good takes the window result only after the result has disagreed with it for a programmed number of consecutive ticks. A typical setting is a lower threshold of 2864 mV, an upper threshold of 3072 mV and 160 mV of hysteresis on each limit. The settle time comes from the tick period and the programmed count; a 64 ms settle time is the usual choice.

Top module: `supply_window_mon`

## Requirements
- R1: After reset the under-voltage flag is 1, the over-voltage flag is 0 and supply-good is 0.
- R2: While the under-voltage flag is set, a sample strictly greater than the lower threshold clears the flag on the next clock. A sample equal to the threshold leaves the flag set.
- R3: While the under-voltage flag is clear, the flag sets on the next clock only when the sample is strictly below (lower threshold minus lower hysteresis). At that value or above, the flag stays clear.
- R4: While the over-voltage flag is clear, a sample strictly greater than the upper threshold sets the flag on the next clock. A sample equal to the threshold leaves the flag clear.
- R5: While the over-voltage flag is set, the flag clears on the next clock only when the sample is strictly below (upper threshold minus upper hysteresis). At that value or above, the flag stays set.
- R6: When a hysteresis value exceeds its threshold, the release point saturates at 0 and does not wrap. A flag that depends on a sample below that point therefore never changes on a sample of 0.
- R7: Supply-good takes the window result (1 when both flags are clear) on the clock of the Nth consecutive tick on which the two differ. N is the filter length. A filter length of 0 acts as 1.
- R8: If the window result returns to the value of supply-good before the count expires, the tick count restarts from zero.
- R9: Supply-good never changes on a clock whose tick input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample | input | 12 | Supply reading, 1 mV per LSB |
| uv_thresh | input | 12 | Lower limit threshold (mV) |
| uv_hyst | input | 12 | Lower limit hysteresis (mV) |
| ov_thresh | input | 12 | Upper limit threshold (mV) |
| ov_hyst | input | 12 | Upper limit hysteresis (mV) |
| filt_len | input | 16 | Settle filter length in ticks |
| tick | input | 1 | Timebase strobe, one clock wide |
| supply_good | output | 1 | Filtered in-window flag |
| uv_flag | output | 1 | Raw under-voltage flag |
| ov_flag | output | 1 | Raw over-voltage flag |

## Verification
The assertions assume that sample, the thresholds and the hysteresis values are synchronous to clk. They also assume that tick is a single-cycle strobe. They place no demand on the relative order of the two thresholds. The stimulus changes every input on the falling clock edge. It holds tick high for exactly one clock at a time. It changes the filter length only while supply-good already matches the window result, so that no count in progress is cut short.

// File: rtl/swm_pkg.sv
package swm_pkg;
  localparam int unsigned DEF_SAMPLE_W  = 12;
  localparam int unsigned DEF_FILT_W    = 16;
  localparam int unsigned DEF_UV_MV     = 2864;
  localparam int unsigned DEF_OV_MV     = 3072;
  localparam int unsigned DEF_HYST_MV   = 160;

  typedef enum logic { FLAG_WHEN_ABOVE = 1'b0, FLAG_WHEN_BELOW = 1'b1 } flag_sense_e;
endpackage

// File: rtl/swm_hyst_cmp.sv
module swm_hyst_cmp
  import swm_pkg::*;
#(
  parameter int unsigned W     = DEF_SAMPLE_W,
  parameter flag_sense_e SENSE = FLAG_WHEN_ABOVE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sample,
  input  logic [W-1:0] thresh,
  input  logic [W-1:0] hyst,
  output logic         flag
);
  // Release point of the limit, saturating at zero.
  function automatic logic [W-1:0] release_point(input logic [W-1:0] t, input logic [W-1:0] h);
    return (h > t) ? '0 : (t - h);
  endfunction

  logic         above_q;
  logic [W-1:0] rel_lvl;
  logic         rise_evt;
  logic         fall_evt;

  assign rel_lvl  = release_point(thresh, hyst);
  assign rise_evt = !above_q && (sample > thresh);
  assign fall_evt = above_q && (sample < rel_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        above_q <= 1'b0;
    else if (rise_evt) above_q <= 1'b1;
    else if (fall_evt) above_q <= 1'b0;
  end

  generate
    if (SENSE == FLAG_WHEN_BELOW) begin : g_below
      assign flag = !above_q;
    end else begin : g_above
      assign flag = above_q;
    end
  endgenerate

  AST_RISE_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    (!above_q && sample > thresh) |=> above_q); // R2
  AST_NO_RISE_AT_THR: assert property (@(posedge clk) disable iff (!rst_n)
    (!above_q && sample <= thresh) |=> !above_q); // R4
  AST_HOLD_IN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    (above_q && sample >= release_point(thresh, hyst)) |=> above_q); // R3
  AST_FALL_BELOW_REL: assert property (@(posedge clk) disable iff (!rst_n)
    (above_q && sample < release_point(thresh, hyst)) |=> !above_q); // R5
endmodule

// File: rtl/swm_settle.sv
module swm_settle
  import swm_pkg::*;
#(
  parameter int unsigned CW = DEF_FILT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raw_ok,
  input  logic          tick,
  input  logic [CW-1:0] len,
  output logic          good
);
  localparam int unsigned XW = CW + 1;

  function automatic logic [XW-1:0] eff_len(input logic [CW-1:0] l);
    return (l == '0) ? XW'(1) : {1'b0, l};
  endfunction

  logic [CW-1:0] cnt_q;
  logic          good_q;
  logic          mismatch;
  logic          expire;

  assign mismatch = (raw_ok != good_q);
  assign expire   = tick && mismatch && (({1'b0, cnt_q} + XW'(1)) >= eff_len(len));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      good_q <= 1'b0;
    end else if (!mismatch) begin
      cnt_q  <= '0;
    end else if (expire) begin
      cnt_q  <= '0;
      good_q <= raw_ok;
    end else if (tick) begin
      cnt_q  <= cnt_q + CW'(1);
    end
  end

  assign good = good_q;

  AST_RESTART_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !mismatch |=> (cnt_q == '0)); // R8
  AST_HOLD_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !mismatch |=> $stable(good_q)); // R7
  AST_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(good_q)); // R9
endmodule

// File: rtl/supply_window_mon.sv
module supply_window_mon
  import swm_pkg::*;
#(
  parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
  parameter int unsigned FILT_W   = DEF_FILT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [SAMPLE_W-1:0] uv_thresh,
  input  logic [SAMPLE_W-1:0] uv_hyst,
  input  logic [SAMPLE_W-1:0] ov_thresh,
  input  logic [SAMPLE_W-1:0] ov_hyst,
  input  logic [FILT_W-1:0]   filt_len,
  input  logic                tick,
  output logic                supply_good,
  output logic                uv_flag,
  output logic                ov_flag
);
  logic in_window;

  swm_hyst_cmp #(.W(SAMPLE_W), .SENSE(FLAG_WHEN_BELOW)) u_uv (
    .clk(clk), .rst_n(rst_n), .sample(sample),
    .thresh(uv_thresh), .hyst(uv_hyst), .flag(uv_flag)
  );

  swm_hyst_cmp #(.W(SAMPLE_W), .SENSE(FLAG_WHEN_ABOVE)) u_ov (
    .clk(clk), .rst_n(rst_n), .sample(sample),
    .thresh(ov_thresh), .hyst(ov_hyst), .flag(ov_flag)
  );

  assign in_window = !uv_flag && !ov_flag;

  swm_settle #(.CW(FILT_W)) u_settle (
    .clk(clk), .rst_n(rst_n), .raw_ok(in_window),
    .tick(tick), .len(filt_len), .good(supply_good)
  );

  AST_GOOD_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_good == in_window) |=> $stable(supply_good)); // R7
endmodule

// File: tb/supply_window_mon_bench.sv
module supply_window_mon_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] sample = '0;
  logic [11:0] uv_thresh = 12'd2864, uv_hyst = 12'd160;
  logic [11:0] ov_thresh = 12'd3072, ov_hyst = 12'd160;
  logic [15:0] filt_len = 16'd4;
  logic        tick = 1'b0;
  logic        supply_good, uv_flag, ov_flag;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  supply_window_mon u_supply_window_mon (
    .clk(clk), .rst_n(rst_n), .sample(sample),
    .uv_thresh(uv_thresh), .uv_hyst(uv_hyst),
    .ov_thresh(ov_thresh), .ov_hyst(ov_hyst),
    .filt_len(filt_len), .tick(tick),
    .supply_good(supply_good), .uv_flag(uv_flag), .ov_flag(ov_flag)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [11:0] v);
    @(negedge clk) sample = v;
    @(negedge clk);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    check("R1", "uv after reset", uv_flag, 1'b1);
    check("R1", "ov after reset", ov_flag, 1'b0);
    check("R1", "good after reset", supply_good, 1'b0);
  endtask

  task automatic t_uv();
    put(12'd2864); check("R2", "uv at threshold", uv_flag, 1'b1);
    put(12'd2865); check("R2", "uv above threshold", uv_flag, 1'b0);
    put(12'd2704); check("R3", "uv at release", uv_flag, 1'b0);
    put(12'd2703); check("R3", "uv below release", uv_flag, 1'b1);
    put(12'd2865); check("R2", "uv clears again", uv_flag, 1'b0);
  endtask

  task automatic t_ov();
    put(12'd3072); check("R4", "ov at threshold", ov_flag, 1'b0);
    put(12'd3073); check("R4", "ov above threshold", ov_flag, 1'b1);
    put(12'd2912); check("R5", "ov at release", ov_flag, 1'b1);
    put(12'd2911); check("R5", "ov below release", ov_flag, 1'b0);
    repeat (20) @(negedge clk);
    check("R9", "good without ticks", supply_good, 1'b0);
  endtask

  task automatic t_filter();
    put(12'd3000);
    pulse(3); check("R7", "good before count ends", supply_good, 1'b0);
    pulse(1); check("R7", "good at count end", supply_good, 1'b1);
  endtask

  task automatic t_restart();
    put(12'd3200); check("R4", "ov for restart", ov_flag, 1'b1);
    pulse(2);
    put(12'd2800); check("R5", "ov back clear", ov_flag, 1'b0);
    pulse(1);
    put(12'd3200);
    pulse(3); check("R8", "good after restart 3 ticks", supply_good, 1'b1);
    pulse(1); check("R8", "good after restart 4 ticks", supply_good, 1'b0);
  endtask

  task automatic t_zero_len();
    @(negedge clk) filt_len = 16'd0;
    put(12'd2800);
    check("R9", "good before tick", supply_good, 1'b0);
    pulse(1); check("R7", "length 0 acts as 1", supply_good, 1'b1);
  endtask

  task automatic t_saturate();
    @(negedge clk) begin uv_thresh = 12'd100; uv_hyst = 12'd200; end
    put(12'd150); check("R6", "uv clear above small thr", uv_flag, 1'b0);
    put(12'd0);   check("R6", "uv not set at zero", uv_flag, 1'b0);
    @(negedge clk) begin ov_thresh = 12'd50; ov_hyst = 12'd100; end
    put(12'd60);  check("R4", "ov set above small thr", ov_flag, 1'b1);
    put(12'd0);   check("R6", "ov not cleared at zero", ov_flag, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_uv();
    t_ov();
    t_filter();
    t_restart();
    t_zero_len();
    t_saturate();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule